// File: doc/BRIEF.md
# CPU Bus Address Decoder

This block sits on the 16-bit address bus of an 8-bit processor. It turns each access into one device select and a local address for that device. The devices are a small internal RAM, a window of eight video registers, a block of 32 I/O registers, an expansion region, 8 KB of battery-backed work RAM and banked program ROM. Mirrored regions are folded inside the block, so each device sees only its own local address bits and never the mirror copies.

Program ROM is reached through four 8 KB windows, and each window has its own page register. Switching a bank is therefore a single register write, not a copy of memory. The physical ROM address is formed as the window's page number times 0x2000 plus the low 13 CPU address bits.

The block also returns read data to the CPU. It muxes in the byte from the selected device. When nothing answers, it returns the value last seen on the data bus, as an open bus would. Decoding of mapper-specific bank writes is left to the logic around it, which drives the bank-write port.

Top module: `cpu_addr_decoder`

## Requirements
- R1: With `cpu_valid` high, addresses 0x0000–0x1FFF assert `dev_sel` bit 0 (RAM), and `ram_addr` equals the address ANDed with 0x7FF, so the 2 KB RAM repeats four times.
- R2: Zero-page addresses 0x0000–0x00FF always select RAM alone, and `ram_addr` equals the address unchanged.
- R3: Addresses 0x2000–0x3FFF assert `dev_sel` bit 1 (video registers), and `vid_idx` equals the address ANDed with 7.
- R4: Addresses 0x4000–0x401F assert `dev_sel` bit 2 (I/O registers), and `io_idx` equals the address ANDed with 0x1F.
- R5: Addresses 0x4020–0x5FFF assert `dev_sel` bit 3 with `exp_addr` = address AND 0x1FFF when parameter `EXP_PRESENT` is 1. When it is 0, that range asserts no select.
- R6: Addresses 0x6000–0x7FFF assert `dev_sel` bit 4 (work RAM), and `wram_addr` equals the address ANDed with 0x1FFF.
- R7: Addresses 0x8000–0xFFFF assert `dev_sel` bit 5 (ROM). `rom_addr` equals page[w]·0x2000 + (address AND 0x1FFF), where the window w is address bits 14:13.
- R8: After reset, windows 0, 1, 2 and 3 hold pages 0, 1, N−2 and N−1, where N = 2^`PAGE_W`.
- R9: A cycle with `bank_we` high loads `bank_page` into window `bank_win` at the clock edge, and the new page is used from the next cycle on. Every other window keeps its page.
- R10: At most one `dev_sel` bit is high, and all bits are low while `cpu_valid` is low.
- R11: `bus_we` equals `cpu_valid` AND `cpu_wr`, except in ROM space (0x8000–0xFFFF), where it stays low, so a ROM write changes nothing.
- R12: On a read, `cpu_rdata` is byte k of `dev_rdata` (bits 8k+7:8k) when select bit k is high. With no select, it is the last bus value: the write data or returned read data of the most recent valid access, or 0x00 after reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| cpu_valid | input | 1 | An access is in progress this cycle |
| cpu_wr | input | 1 | 1 = write, 0 = read |
| cpu_addr | input | 16 | CPU address |
| cpu_wdata | input | 8 | CPU write data |
| bank_we | input | 1 | Load a ROM window page register |
| bank_win | input | 2 | Window index for the page load |
| bank_page | input | PAGE_W | Page number to load |
| dev_rdata | input | 48 | Read bytes from the six devices, byte k for select bit k |
| dev_sel | output | 6 | One-hot device select (RAM, video, I/O, expansion, work RAM, ROM) |
| ram_addr | output | 11 | Folded internal RAM address |
| vid_idx | output | 3 | Video register index |
| io_idx | output | 5 | I/O register index |
| exp_addr | output | 13 | Expansion region local address |
| wram_addr | output | 13 | Work RAM local address |
| rom_addr | output | PAGE_W+13 | Physical program ROM address |
| bus_we | output | 1 | Write strobe to writable devices |
| cpu_rdata | output | 8 | Read data returned to the CPU |

## Verification
The bench builds two copies of the block. The main copy uses `PAGE_W`=6 and `EXP_PRESENT`=0. Leaving the expansion region unpopulated makes open-bus reads reachable, and 64 pages put the reset pages of the upper windows at 62 and 63. The second copy uses `PAGE_W`=4 and `EXP_PRESENT`=1. It covers the populated expansion select and a different set of reset pages (14 and 15), which shows that the reset defaults follow the page width.

// File: rtl/cpu_dec_pkg.sv
// Shared constants and types for the CPU bus address decoder.
// Assumes a 16-bit address bus and an 8-bit data bus.
package cpu_dec_pkg;
    localparam int CPU_AW  = 16;
    localparam int DATA_W  = 8;
    localparam int NUM_DEV = 6;

    // Device select bit positions
    localparam int SEL_RAM  = 0;
    localparam int SEL_VID  = 1;
    localparam int SEL_IO   = 2;
    localparam int SEL_EXP  = 3;
    localparam int SEL_WRAM = 4;
    localparam int SEL_ROM  = 5;

    // Region base addresses (each region ends at the next base)
    localparam logic [CPU_AW-1:0] VID_BASE  = 16'h2000;
    localparam logic [CPU_AW-1:0] IO_BASE   = 16'h4000;
    localparam logic [CPU_AW-1:0] EXP_BASE  = 16'h4020;
    localparam logic [CPU_AW-1:0] WRAM_BASE = 16'h6000;
    localparam logic [CPU_AW-1:0] ROM_BASE  = 16'h8000;

    // Local address widths after folding mirrors
    localparam int RAM_AW  = 11;
    localparam int VID_IW  = 3;
    localparam int IO_IW   = 5;
    localparam int WIN_AW  = 13;
    localparam int NUM_WIN = 4;
    localparam int WIN_IW  = $clog2(NUM_WIN);

    typedef logic [CPU_AW-1:0]  cpu_addr_t;
    typedef logic [DATA_W-1:0]  data_t;
    typedef logic [NUM_DEV-1:0] dev_sel_t;
endpackage

// File: rtl/addr_region_decode.sv
// Combinational region decode: classifies a CPU address into one device
// select and folds mirrors into local addresses.
// Assumes the regions in cpu_dec_pkg cover the whole address space in order.
module addr_region_decode
    import cpu_dec_pkg::*;
#(
    parameter bit EXP_PRESENT = 1'b0
) (
    input  logic              valid,
    input  cpu_addr_t         addr,
    output dev_sel_t          hit,
    output logic [RAM_AW-1:0] ram_addr,
    output logic [VID_IW-1:0] vid_idx,
    output logic [IO_IW-1:0]  io_idx,
    output logic [WIN_AW-1:0] win_off,
    output logic [WIN_IW-1:0] win_idx
);
    // Select exactly one region for a valid access; none when idle
    always_comb begin
        hit = '0;
        if (valid) begin
            if (addr < VID_BASE)        hit[SEL_RAM]  = 1'b1;
            else if (addr < IO_BASE)    hit[SEL_VID]  = 1'b1;
            else if (addr < EXP_BASE)   hit[SEL_IO]   = 1'b1;
            else if (addr < WRAM_BASE)  hit[SEL_EXP]  = EXP_PRESENT;
            else if (addr < ROM_BASE)   hit[SEL_WRAM] = 1'b1;
            else                        hit[SEL_ROM]  = 1'b1;
        end
    end

    // Fold mirrors: keep only the bits each device decodes
    always_comb begin
        ram_addr = addr[RAM_AW-1:0];
        vid_idx  = addr[VID_IW-1:0];
        io_idx   = addr[IO_IW-1:0];
        win_off  = addr[WIN_AW-1:0];
        win_idx  = addr[WIN_AW +: WIN_IW];
    end
endmodule

// File: rtl/rom_bank_regs.sv
// Page registers for the ROM windows and the physical ROM address former.
// Assumes PAGE_W >= 2. The reset pages put the two upper windows on the
// last two pages, so the reset vector lands in the last page.
module rom_bank_regs
    import cpu_dec_pkg::*;
#(
    parameter int PAGE_W = 6
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     wr_en,
    input  logic [WIN_IW-1:0]        wr_win,
    input  logic [PAGE_W-1:0]        wr_page,
    input  logic [WIN_IW-1:0]        rd_win,
    input  logic [WIN_AW-1:0]        rd_off,
    output logic [PAGE_W+WIN_AW-1:0] rom_addr
);
    localparam int NUM_PAGES = 1 << PAGE_W;

    logic [PAGE_W-1:0] page_q [NUM_WIN];

    for (genvar w = 0; w < NUM_WIN; w++) begin : g_win
        localparam int RST_I = (w < NUM_WIN/2) ? w : NUM_PAGES - NUM_WIN + w;
        // Hold one window's page; load on a matching bank write
        always_ff @(posedge clk) begin
            if (!rst_n)
                page_q[w] <= PAGE_W'(RST_I);
            else if (wr_en && (wr_win == WIN_IW'(w)))
                page_q[w] <= wr_page;
        end
    end

    // Physical address: page times window size plus offset
    always_comb rom_addr = {page_q[rd_win], rd_off};
endmodule

// File: rtl/bus_return.sv
// Read-data return path: muxes the selected device byte and keeps the
// last bus value for reads that no device answers.
// Assumes at most one hit bit is high.
module bus_return
    import cpu_dec_pkg::*;
(
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    valid,
    input  logic                    wr,
    input  data_t                   wdata,
    input  dev_sel_t                hit,
    input  logic [NUM_DEV*DATA_W-1:0] dev_rdata,
    output data_t                   rdata
);
    data_t last_q;
    data_t pick [NUM_DEV+1];

    // Chain of muxes: default is the held bus value
    assign pick[0] = last_q;
    for (genvar k = 0; k < NUM_DEV; k++) begin : g_pick
        assign pick[k+1] = hit[k] ? dev_rdata[k*DATA_W +: DATA_W] : pick[k];
    end
    assign rdata = pick[NUM_DEV];

    // Remember what last travelled on the data bus
    always_ff @(posedge clk) begin
        if (!rst_n)
            last_q <= '0;
        else if (valid)
            last_q <= wr ? wdata : rdata;
    end
endmodule

// File: rtl/cpu_addr_decoder.sv
// Top of the CPU bus address decoder: region decode, banked ROM address,
// write strobe gating and read-data return.
// Assumes one access per cycle qualified by cpu_valid.
module cpu_addr_decoder
    import cpu_dec_pkg::*;
#(
    parameter int PAGE_W      = 6,
    parameter bit EXP_PRESENT = 1'b0
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     cpu_valid,
    input  logic                     cpu_wr,
    input  logic [15:0]              cpu_addr,
    input  logic [7:0]               cpu_wdata,
    input  logic                     bank_we,
    input  logic [1:0]               bank_win,
    input  logic [PAGE_W-1:0]        bank_page,
    input  logic [47:0]              dev_rdata,
    output logic [5:0]               dev_sel,
    output logic [10:0]              ram_addr,
    output logic [2:0]               vid_idx,
    output logic [4:0]               io_idx,
    output logic [12:0]              exp_addr,
    output logic [12:0]              wram_addr,
    output logic [PAGE_W+12:0]       rom_addr,
    output logic                     bus_we,
    output logic [7:0]               cpu_rdata
);
    logic [WIN_AW-1:0] win_off;
    logic [WIN_IW-1:0] win_idx;

    addr_region_decode #(.EXP_PRESENT(EXP_PRESENT)) u_dec (
        .valid    (cpu_valid),
        .addr     (cpu_addr),
        .hit      (dev_sel),
        .ram_addr (ram_addr),
        .vid_idx  (vid_idx),
        .io_idx   (io_idx),
        .win_off  (win_off),
        .win_idx  (win_idx)
    );

    rom_bank_regs #(.PAGE_W(PAGE_W)) u_bank (
        .clk      (clk),
        .rst_n    (rst_n),
        .wr_en    (bank_we),
        .wr_win   (bank_win),
        .wr_page  (bank_page),
        .rd_win   (win_idx),
        .rd_off   (win_off),
        .rom_addr (rom_addr)
    );

    bus_return u_ret (
        .clk       (clk),
        .rst_n     (rst_n),
        .valid     (cpu_valid),
        .wr        (cpu_wr),
        .wdata     (cpu_wdata),
        .hit       (dev_sel),
        .dev_rdata (dev_rdata),
        .rdata     (cpu_rdata)
    );

    // Local offsets for the two 8 KB regions
    assign exp_addr  = win_off;
    assign wram_addr = win_off;

    // Writes reach every region except ROM
    assign bus_we = cpu_valid && cpu_wr && !(cpu_addr >= ROM_BASE);
endmodule

// File: rtl/cpu_addr_decoder_chk.sv
// Checker bound to cpu_addr_decoder: select exclusivity, zero page,
// ROM write gating, bank update timing and open-bus return.
module cpu_addr_decoder_chk #(
    parameter int PAGE_W = 6
) (
    input logic               clk,
    input logic               rst_n,
    input logic               cpu_valid,
    input logic               cpu_wr,
    input logic [15:0]        cpu_addr,
    input logic [7:0]         cpu_wdata,
    input logic               bank_we,
    input logic [1:0]         bank_win,
    input logic [PAGE_W-1:0]  bank_page,
    input logic [5:0]         dev_sel,
    input logic [10:0]        ram_addr,
    input logic [PAGE_W+12:0] rom_addr,
    input logic               bus_we,
    input logic [7:0]         cpu_rdata
);
    // R10
    sel_onehot_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(dev_sel));

    // R10
    idle_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !cpu_valid |-> dev_sel == 6'b0);

    // R2
    zero_page_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (cpu_valid && cpu_addr[15:8] == 8'h00) |->
            (dev_sel == 6'b000001 && ram_addr == {3'b000, cpu_addr[7:0]}));

    // R11
    rom_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (cpu_valid && cpu_addr[15]) |-> !bus_we);

    // R9
    bank_update_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rst_n) && $past(bank_we) && cpu_valid && cpu_addr[15]
            && cpu_addr[14:13] == $past(bank_win))
            |-> rom_addr[PAGE_W+12:13] == $past(bank_page));

    // R12
    open_bus_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rst_n) && $past(cpu_valid && cpu_wr) && cpu_valid && !cpu_wr
            && dev_sel == 6'b0) |-> cpu_rdata == $past(cpu_wdata));
endmodule

bind cpu_addr_decoder cpu_addr_decoder_chk #(.PAGE_W(PAGE_W)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .cpu_valid (cpu_valid),
    .cpu_wr    (cpu_wr),
    .cpu_addr  (cpu_addr),
    .cpu_wdata (cpu_wdata),
    .bank_we   (bank_we),
    .bank_win  (bank_win),
    .bank_page (bank_page),
    .dev_sel   (dev_sel),
    .ram_addr  (ram_addr),
    .rom_addr  (rom_addr),
    .bus_we    (bus_we),
    .cpu_rdata (cpu_rdata)
);

// File: tb/cpu_addr_decoder_test.sv
module cpu_addr_decoder_test;
    localparam int CLK_PERIOD = 10;
    localparam int PW  = 6;
    localparam int PWX = 4;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        cpu_valid = 1'b0;
    logic        cpu_wr = 1'b0;
    logic [15:0] cpu_addr = '0;
    logic [7:0]  cpu_wdata = '0;
    logic        bank_we = 1'b0;
    logic [1:0]  bank_win = '0;
    logic [PW-1:0] bank_page = '0;
    logic [47:0] dev_rdata = '0;

    logic [5:0]  dev_sel, x_sel;
    logic [10:0] ram_addr, x_ram;
    logic [2:0]  vid_idx, x_vid;
    logic [4:0]  io_idx, x_io;
    logic [12:0] exp_addr, wram_addr, x_exp, x_wram;
    logic [PW+12:0]  rom_addr;
    logic [PWX+12:0] x_rom;
    logic        bus_we, x_we;
    logic [7:0]  cpu_rdata, x_rdata;

    always #(CLK_PERIOD/2) clk = ~clk;

    cpu_addr_decoder #(.PAGE_W(PW), .EXP_PRESENT(1'b0)) uut (
        .clk(clk), .rst_n(rst_n), .cpu_valid(cpu_valid), .cpu_wr(cpu_wr),
        .cpu_addr(cpu_addr), .cpu_wdata(cpu_wdata), .bank_we(bank_we),
        .bank_win(bank_win), .bank_page(bank_page), .dev_rdata(dev_rdata),
        .dev_sel(dev_sel), .ram_addr(ram_addr), .vid_idx(vid_idx),
        .io_idx(io_idx), .exp_addr(exp_addr), .wram_addr(wram_addr),
        .rom_addr(rom_addr), .bus_we(bus_we), .cpu_rdata(cpu_rdata));

    cpu_addr_decoder #(.PAGE_W(PWX), .EXP_PRESENT(1'b1)) uut_x (
        .clk(clk), .rst_n(rst_n), .cpu_valid(cpu_valid), .cpu_wr(cpu_wr),
        .cpu_addr(cpu_addr), .cpu_wdata(cpu_wdata), .bank_we(1'b0),
        .bank_win(2'b00), .bank_page(4'h0), .dev_rdata(dev_rdata),
        .dev_sel(x_sel), .ram_addr(x_ram), .vid_idx(x_vid),
        .io_idx(x_io), .exp_addr(x_exp), .wram_addr(x_wram),
        .rom_addr(x_rom), .bus_we(x_we), .cpu_rdata(x_rdata));

    int n_checks = 0;
    int n_fail   = 0;
    bit finished = 1'b0;
    string rom_tag = "R7";

    // Bench model state
    int unsigned pg [4];
    logic [7:0]  last_bus;

    task automatic chk(input bit ok, input string tag, input longint act, input longint expv);
        n_checks++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s: actual 0x%0h expected 0x%0h (addr 0x%04h)", tag, act, expv, cpu_addr);
        end
    endtask

    function automatic logic [5:0] ref_sel(input logic [15:0] a, input bit v, input bit expon);
        if (!v) return 6'b0;
        if (a <= 16'h1FFF) return 6'b000001;
        if (a <= 16'h3FFF) return 6'b000010;
        if (a <= 16'h401F) return 6'b000100;
        if (a <= 16'h5FFF) return expon ? 6'b001000 : 6'b000000;
        if (a <= 16'h7FFF) return 6'b010000;
        return 6'b100000;
    endfunction

    function automatic int unsigned ref_rom(input logic [15:0] a);
        return pg[a[14:13]] * 32'h2000 + (a & 16'h1FFF);
    endfunction

    function automatic logic [7:0] ref_rd(input logic [5:0] s, input logic [47:0] d);
        for (int k = 0; k < 6; k++)
            if (s[k]) return d[k*8 +: 8];
        return last_bus;
    endfunction

    task automatic access(input logic [15:0] a, input bit wr, input bit v,
                          input logic [7:0] wd, input bit bwe,
                          input logic [1:0] bw, input logic [PW-1:0] bp);
        logic [5:0] es;
        logic [7:0] er;
        @(negedge clk);
        cpu_addr = a; cpu_wr = wr; cpu_valid = v; cpu_wdata = wd;
        bank_we = bwe; bank_win = bw; bank_page = bp;
        dev_rdata = {$urandom, $urandom};
        #1;
        es = ref_sel(a, v, 1'b0);
        chk(dev_sel == es, v ? "R1-sel" : "R10", dev_sel, es);
        if (es[0]) begin
            if (a < 16'h0100) chk(ram_addr == a[10:0], "R2", ram_addr, a);
            else chk(ram_addr == (a & 16'h07FF), "R1", ram_addr, a & 16'h07FF);
        end
        if (es[1]) chk(vid_idx == (a & 16'h7), "R3", vid_idx, a & 16'h7);
        if (es[2]) chk(io_idx == (a & 16'h1F), "R4", io_idx, a & 16'h1F);
        if (v && a >= 16'h4020 && a <= 16'h5FFF) chk(dev_sel == 6'b0, "R5", dev_sel, 0);
        if (es[4]) chk(wram_addr == (a & 16'h1FFF), "R6", wram_addr, a & 16'h1FFF);
        if (es[5]) chk(rom_addr == ref_rom(a), rom_tag, rom_addr, ref_rom(a));
        chk(bus_we == (v && wr && a < 16'h8000), "R11", bus_we, v && wr && a < 16'h8000);
        er = ref_rd(es, dev_rdata);
        if (v && !wr) chk(cpu_rdata == er, "R12", cpu_rdata, er);
        @(posedge clk);
        if (v) last_bus = wr ? wd : er;
        if (bwe) pg[bw] = bp;
    endtask

    // Watchdog: a hung run counts as a failure and still reports
    initial begin
        for (int c = 0; c < 200000; c++) begin
            @(posedge clk);
            if (finished) break;
        end
        if (!finished) begin
            n_fail++;
            $display("FAIL watchdog: run did not complete");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_checks, n_fail);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'h5EED_0042));
        pg[0] = 0; pg[1] = 1; pg[2] = (1 << PW) - 2; pg[3] = (1 << PW) - 1;
        last_bus = 8'h00;
        bank_we = 1'b1; bank_page = 6'h2A;   // ignored under reset
        repeat (3) @(posedge clk);
        @(negedge clk);
        bank_we = 1'b0;
        rst_n = 1'b1;

        // R12: open bus reads 0x00 straight after reset
        access(16'h4800, 1'b0, 1'b1, 8'h00, 1'b0, 2'd0, '0);

        // R8: reset pages in every window
        rom_tag = "R8";
        access(16'h8000, 1'b0, 1'b1, 8'h00, 1'b0, 2'd0, '0);
        access(16'hA123, 1'b0, 1'b1, 8'h00, 1'b0, 2'd0, '0);
        access(16'hC456, 1'b0, 1'b1, 8'h00, 1'b0, 2'd0, '0);
        access(16'hFFFC, 1'b0, 1'b1, 8'h00, 1'b0, 2'd0, '0);

        // Second build: populated expansion and 16 pages
        @(negedge clk);
        cpu_valid = 1'b1; cpu_wr = 1'b0; cpu_addr = 16'h5234; #1;
        chk(x_sel == 6'b001000, "R5", x_sel, 6'b001000);
        chk(x_exp == 13'h1234, "R5", x_exp, 13'h1234);
        cpu_addr = 16'hC010; #1;
        chk(x_rom == 17'(14 * 32'h2000 + 32'h10), "R8", x_rom, 14 * 32'h2000 + 32'h10);
        cpu_addr = 16'hE010; #1;
        chk(x_rom == 17'(15 * 32'h2000 + 32'h10), "R8", x_rom, 15 * 32'h2000 + 32'h10);
        cpu_addr = 16'h4020; #1;
        chk(x_sel == 6'b001000, "R5", x_sel, 6'b001000);
        cpu_addr = 16'h401F; #1;
        chk(x_sel == 6'b000100, "R4", x_sel, 6'b000100);
        cpu_valid = 1'b0;

        // R9: bank write visible next cycle, other windows held
        rom_tag = "R9";
        access(16'h0000, 1'b0, 1'b0, 8'h00, 1'b1, 2'd2, 6'd5);
        access(16'hC123, 1'b0, 1'b1, 8'h00, 1'b0, 2'd0, '0);
        access(16'hE001, 1'b0, 1'b1, 8'h00, 1'b0, 2'd0, '0);
        access(16'h8001, 1'b0, 1'b1, 8'h00, 1'b1, 2'd0, 6'd33);
        access(16'h8001, 1'b0, 1'b1, 8'h00, 1'b0, 2'd0, '0);
        rom_tag = "R7";

        // R11 with R12: ROM write gated; open bus follows write data
        access(16'h9000, 1'b1, 1'b1, 8'h3C, 1'b0, 2'd0, '0);
        access(16'h5FFF, 1'b0, 1'b1, 8'h00, 1'b0, 2'd0, '0);
        access(16'h0010, 1'b1, 1'b1, 8'hA5, 1'b0, 2'd0, '0);
        access(16'h4020, 1'b0, 1'b1, 8'h00, 1'b0, 2'd0, '0);

        // Boundaries and mirrors
        access(16'h00FF, 1'b0, 1'b1, 8'h00, 1'b0, 2'd0, '0);
        access(16'h1FFF, 1'b0, 1'b1, 8'h00, 1'b0, 2'd0, '0);
        access(16'h2000, 1'b0, 1'b1, 8'h00, 1'b0, 2'd0, '0);
        access(16'h3FFF, 1'b1, 1'b1, 8'h11, 1'b0, 2'd0, '0);
        access(16'h4000, 1'b0, 1'b1, 8'h00, 1'b0, 2'd0, '0);
        access(16'h401F, 1'b0, 1'b1, 8'h00, 1'b0, 2'd0, '0);
        access(16'h6000, 1'b1, 1'b1, 8'h22, 1'b0, 2'd0, '0);
        access(16'h7FFF, 1'b0, 1'b1, 8'h00, 1'b0, 2'd0, '0);
        access(16'h7FFF, 1'b1, 1'b0, 8'h00, 1'b0, 2'd0, '0);

        // Constrained random traffic
        for (int i = 0; i < 4000; i++) begin
            logic [15:0] a;
            int unsigned r;
            r = $urandom_range(0, 9);
            a = 16'($urandom);
            if (r < 2) a = {8'h00, a[7:0]};
            else if (r == 2) a = 16'h4000 | 16'(a[5:0]);
            access(a, 1'($urandom_range(0, 2) == 0), 1'($urandom_range(0, 7) != 0),
                   8'($urandom), 1'($urandom_range(0, 9) == 0),
                   2'($urandom), PW'($urandom));
        end

        finished = 1'b1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_checks, n_fail);
        $finish;
    end
endmodule